// File: doc/BRIEF.md
# Parallel Host Port Slave Controller

This block is the peripheral end of a byte-wide, asynchronous parallel host port. The port uses an address strobe, a data strobe, a write/read pin, a wait line and a bidirectional data byte. The tri-state byte is split into an input, an output and an output-enable pin. The controller resynchronises the host pins, runs a seven-state handshake machine, and keeps an 8-bit address register that the host can write and read back. Towards user logic it presents the address, the host write byte, a one-cycle write pulse and a read-cycle flag, and it takes back a read byte.

Some user registers need more than a register transfer. User logic raises a handshake request for them, usually decoded from the address. On a data cycle the controller then fires a one-cycle start pulse. It withholds the host wait line until user logic reports done. The only back-pressure on the port is this wait line. The write pulse carries no ready: user logic must accept the byte in the cycle it is pulsed.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, host_wait, host_d_oe, usr_start and usr_wr_pulse are low and usr_addr is 0x00.
- R2: A host cycle begins when either strobe goes low. host_wait rises once the transfer is complete and stays high while either strobe is low. It falls again after both strobes return high.
- R3: An address-strobe cycle with host_wr_n low loads host_d_in into the address register seen on usr_addr. Nothing else changes that register except a reset.
- R4: An address-strobe cycle with host_wr_n high drives the address register on host_d_out, with host_d_oe high.
- R5: A data-strobe write cycle without a handshake request gives exactly one usr_wr_pulse carrying host_d_in on usr_wdata, and no usr_start.
- R6: A data-strobe read cycle drives usr_rdata on host_d_out with host_d_oe high. host_d_oe stays low during every write cycle.
- R7: A data-strobe cycle with usr_hs_req high gives exactly one usr_start pulse. host_wait stays low until usr_done has been seen high.
- R8: usr_hs_req has no effect on address-strobe cycles: no usr_start is given, and the transfer completes as a plain register transfer.
- R9: host_rst high returns the state machine to idle and clears the address register to 0x00.
- R10: A data-strobe write cycle with a handshake request gives exactly one usr_wr_pulse, before the start pulse, carrying the write byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_rst | input | 1 | Host port reset pin, active high, synchronised |
| host_astb_n | input | 1 | Address strobe, active low, synchronised |
| host_dstb_n | input | 1 | Data strobe, active low, synchronised |
| host_wr_n | input | 1 | Low for a write, high for a read, synchronised |
| host_d_in | input | 8 | Byte from the host data bus |
| host_d_out | output | 8 | Byte to the host data bus |
| host_d_oe | output | 1 | Drive enable for the host data bus |
| host_wait | output | 1 | Handshake acknowledge to the host |
| usr_addr | output | 8 | Address register contents |
| usr_wdata | output | 8 | Write byte to user logic |
| usr_wr_pulse | output | 1 | One-cycle data write strobe |
| usr_rd_cycle | output | 1 | Current cycle is a host read |
| usr_rdata | input | 8 | Read byte from user logic |
| usr_hs_req | input | 1 | User asks for a process on this data cycle |
| usr_start | output | 1 | One-cycle process start |
| usr_done | input | 1 | Process finished |

## Verification
The assertions assume that the host follows the port protocol. The host sets the write pin and data byte before lowering a strobe and holds them until wait rises. It returns the strobes high only after that, and it holds usr_hs_req steady through the cycle. The bench drives each transfer through one task that obeys that order, changing pins only on the falling clock edge. usr_done is raised only after a start pulse, and host_rst is pulsed only while the port is idle.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_READY  = 3'b000,
    S_STB    = 3'b010,
    S_SETP   = 3'b011,
    S_REGT   = 3'b110,
    S_LAUNCH = 3'b111,
    S_WAITP  = 3'b101,
    S_DONE   = 3'b100
  } hb_state_e;
endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/hostbus_fsm.sv
module hostbus_fsm
  import hostbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hrst,
  input  logic astb_n,
  input  logic dstb_n,
  input  logic wr_n,
  input  logic hs_req,
  input  logic done,
  output logic wait_o,
  output logic start_o,
  output logic addr_we,
  output logic data_we,
  output logic rd_cycle
);
  hb_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_READY:  if (!astb_n || !dstb_n) st_nx = S_STB;
      S_STB:    st_nx = (!dstb_n && hs_req) ? S_SETP : S_REGT;
      S_SETP:   st_nx = S_LAUNCH;
      S_LAUNCH: st_nx = S_WAITP;
      S_WAITP:  if (done) st_nx = S_DONE;
      S_REGT:   st_nx = S_DONE;
      S_DONE:   if (astb_n && dstb_n) st_nx = S_READY;
      default:  st_nx = S_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= S_READY;
    else if (hrst)  st <= S_READY;
    else            st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rd_cycle <= 1'b0;
    else if (hrst)            rd_cycle <= 1'b0;
    else if (st == S_READY)   rd_cycle <= 1'b0;
    else if (st == S_STB)     rd_cycle <= wr_n;
  end

  assign wait_o  = (st == S_DONE);
  assign start_o = (st == S_LAUNCH);
  assign addr_we = (st == S_REGT) && !astb_n && !wr_n;
  assign data_we = ((st == S_REGT) || (st == S_SETP)) && !dstb_n && !wr_n;

  p_wait_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_o) |-> ($past(st) == S_REGT || $past(st) == S_WAITP));

  p_hold_proc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITP && !done && !hrst) |=> (st == S_WAITP));

  p_start_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_wrpulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> !data_we);

  p_rdflag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && $past(st) == S_DONE) |-> $stable(rd_cycle));

  p_hostrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hrst |=> (st == S_READY && !rd_cycle));
endmodule

// File: rtl/hostbus_addr.sv
module hostbus_addr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hrst,
  input  logic         addr_we,
  input  logic [W-1:0] d_in,
  input  logic         astb_n,
  input  logic         rd_cycle,
  input  logic [W-1:0] usr_rdata,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] d_out,
  output logic         d_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (hrst)    addr_q <= '0;
    else if (addr_we) addr_q <= d_in;
  end

  assign d_out = astb_n ? usr_rdata : addr_q;
  assign d_oe  = rd_cycle;

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> ($past(addr_we) || $past(hrst)));

  p_addr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hrst |=> (addr_q == '0));
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hostbus_pkg::*;
#(
  parameter int W           = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_rst,
  input  logic         host_astb_n,
  input  logic         host_dstb_n,
  input  logic         host_wr_n,
  input  logic [W-1:0] host_d_in,
  output logic [W-1:0] host_d_out,
  output logic         host_d_oe,
  output logic         host_wait,
  output logic [W-1:0] usr_addr,
  output logic [W-1:0] usr_wdata,
  output logic         usr_wr_pulse,
  output logic         usr_rd_cycle,
  input  logic [W-1:0] usr_rdata,
  input  logic         usr_hs_req,
  output logic         usr_start,
  input  logic         usr_done
);
  localparam int         NPINS    = 4;
  localparam logic [3:0] PIN_IDLE = 4'b0111;

  logic [NPINS-1:0] pin_raw, pin_s;
  logic addr_we, rd_cycle;

  assign pin_raw = {host_rst, host_wr_n, host_dstb_n, host_astb_n};

  for (genvar i = 0; i < NPINS; i++) begin : g_sync
    hostbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE[i])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[i]), .q(pin_s[i])
    );
  end

  hostbus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hrst(pin_s[3]),
    .astb_n(pin_s[0]), .dstb_n(pin_s[1]), .wr_n(pin_s[2]),
    .hs_req(usr_hs_req), .done(usr_done),
    .wait_o(host_wait), .start_o(usr_start),
    .addr_we(addr_we), .data_we(usr_wr_pulse), .rd_cycle(rd_cycle)
  );

  hostbus_addr #(.W(W)) u_addr (
    .clk(clk), .rst_n(rst_n), .hrst(pin_s[3]), .addr_we(addr_we),
    .d_in(host_d_in), .astb_n(pin_s[0]), .rd_cycle(rd_cycle),
    .usr_rdata(usr_rdata), .addr_q(usr_addr),
    .d_out(host_d_out), .d_oe(host_d_oe)
  );

  assign usr_wdata    = host_d_in;
  assign usr_rd_cycle = rd_cycle;

  p_oe_follows_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_d_oe) |-> $past(pin_s[2]));
endmodule

// File: tb/hostbus_slave_bench.sv
`timescale 1ns/1ps
module hostbus_slave_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, host_rst = 1'b0;
  logic host_astb_n = 1'b1, host_dstb_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_d_in = 8'h00, usr_rdata = 8'h00;
  logic usr_hs_req = 1'b0, usr_done = 1'b0;
  logic [7:0] host_d_out, usr_addr, usr_wdata;
  logic host_d_oe, host_wait, usr_wr_pulse, usr_rd_cycle, usr_start;

  hostbus_slave u_hostbus_slave (
    .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
    .host_astb_n(host_astb_n), .host_dstb_n(host_dstb_n), .host_wr_n(host_wr_n),
    .host_d_in(host_d_in), .host_d_out(host_d_out), .host_d_oe(host_d_oe),
    .host_wait(host_wait), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_wr_pulse(usr_wr_pulse), .usr_rd_cycle(usr_rd_cycle),
    .usr_rdata(usr_rdata), .usr_hs_req(usr_hs_req),
    .usr_start(usr_start), .usr_done(usr_done)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {is_addr, is_read, hs, byte}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'h3C},
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 1'b0, 8'h5A},
    {1'b1, 1'b0, 1'b1, 8'h81},
    {1'b0, 1'b0, 1'b1, 8'h77},
    {1'b0, 1'b1, 1'b1, 8'hC3},
    {1'b1, 1'b1, 1'b0, 8'h81}
  };

  logic [7:0] r_byte, w_byte;
  bit r_oe, early, tout, held, order_ok;
  int n_wr, n_st;

  task automatic xfer(input bit is_addr, input bit is_read, input bit hs,
                      input logic [7:0] b, input int dly);
    int cnt;
    bit given;
    n_wr = 0; n_st = 0; early = 0; tout = 0; held = 1; order_ok = 1;
    w_byte = 8'h00; r_byte = 8'h00; r_oe = 0; given = 0; cnt = -1;
    @(negedge clk);
    host_wr_n = is_read; host_d_in = b; usr_hs_req = hs;
    if (is_read && !is_addr) usr_rdata = b;
    @(negedge clk);
    if (is_addr) host_astb_n = 1'b0; else host_dstb_n = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      usr_done = 1'b0;
      if (usr_wr_pulse) begin n_wr++; w_byte = usr_wdata; if (n_st != 0) order_ok = 0; end
      if (usr_start) begin n_st++; cnt = dly; end
      if (host_wait) begin
        if (hs && !is_addr && !given) early = 1;
        break;
      end
      if (cnt == 0) begin usr_done = 1'b1; given = 1; cnt = -1; end
      else if (cnt > 0) cnt--;
      if (i == 79) tout = 1;
    end
    usr_done = 1'b0;
    r_byte = host_d_out; r_oe = host_d_oe;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!host_wait) held = 0;
      if (usr_wr_pulse) n_wr++;
      if (usr_start) n_st++;
    end
    host_astb_n = 1'b1; host_dstb_n = 1'b1;
    for (int i = 0; i < 10; i++) @(negedge clk);
    if (host_wait) held = 0;
    usr_hs_req = 1'b0; host_wr_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] model_addr;
    model_addr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 wait", host_wait, 0);
    chk("R1 oe", host_d_oe, 0);
    chk("R1 start", usr_start, 0);
    chk("R1 wr_pulse", usr_wr_pulse, 0);
    chk("R1 addr", usr_addr, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic ia, ir, ih;
      logic [7:0] b;
      {ia, ir, ih, b} = VEC[v];
      xfer(ia, ir, ih, b, 3 + v);
      chk("R2 completes", tout, 0);
      chk("R2 wait held while strobe low, released after", held, 1);
      if (ia && !ir) model_addr = b;
      chk("R3 addr register", usr_addr, model_addr);
      if (ia) chk("R8 no start on address cycle", n_st, 0);
      if (ia && ir) begin
        chk("R4 addr read data", r_byte, model_addr);
        chk("R4 addr read oe", r_oe, 1);
      end
      if (ir) chk("R6 oe on read", r_oe, 1);
      else    chk("R6 oe low on write", r_oe, 0);
      if (!ia && ir) chk("R6 read data", r_byte, b);
      if (!ia && !ir && !ih) begin
        chk("R5 one write pulse", n_wr, 1);
        chk("R5 write byte", w_byte, b);
        chk("R5 no start", n_st, 0);
      end
      if (!ia && ih) begin
        chk("R7 one start", n_st, 1);
        chk("R7 wait withheld until done", early, 0);
      end
      if (!ia && !ir && ih) begin
        chk("R10 one write pulse", n_wr, 1);
        chk("R10 write byte", w_byte, b);
        chk("R10 pulse before start", order_ok, 1);
      end
      if (ir || ia) if (!(!ia && !ir)) chk("R5 no write pulse off data write", n_wr, 0);
    end

    // R7 long process delay
    xfer(0, 0, 1, 8'h19, 40);
    chk("R7 long delay start", n_st, 1);
    chk("R7 long delay wait withheld", early, 0);

    // R9 host reset
    @(negedge clk); host_rst = 1'b1;
    repeat (4) @(negedge clk); host_rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 addr cleared", usr_addr, 8'h00);
    chk("R9 idle wait low", host_wait, 0);
    xfer(1, 0, 0, 8'hE2, 0);
    chk("R9 usable after host reset", usr_addr, 8'hE2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule